// File: doc/BRIEF.md
# Squashable Fetch Instruction Queue

This block sits between instruction fetch and the back end of a processor core. Fetch writes one instruction record per cycle. Each record carries a sequence number, which rises with every instruction, and the number of destination registers the instruction will claim. A record first waits in an input stage. A fixed number of cycles after it was accepted, it moves into an output stage. The back end reads from the head of the output stage in show-ahead fashion.

A branch recovery or a trap drives a squash with a sequence number. Every record younger than that number is discarded from both stages and from the latency pipeline, in a single cycle. The block also keeps the count of free physical registers. Accepting a record debits the count by the record's destination count. Squashed records are credited back. The back end returns registers through a release input. When registers run out, fetch is blocked until registers come back.

Two counters gather statistics on the input stage: the running sum of its occupancy and the number of cycles it spent full.

Top module: `squash_fetch_queue`

## Requirements
- R1: After reset, both stages are empty, `deq_valid` is 0, `free_regs` equals PHYS_REGS, `reg_blocked` is 0, `enq_ready` is 1, and both statistics counters are 0.
- R2: A write is taken on a cycle only when all three of these hold: `enq_valid` and `enq_ready` are both 1, and `enq_dst` is not greater than `free_regs`. `enq_ready` is 0 while the input stage holds IN_DEPTH records, and `in_count` never exceeds IN_DEPTH.
- R3: A record taken at clock edge t is visible in the output stage after edge t+LATENCY, provided the output stage has room at that edge. Otherwise it waits and moves at the first edge where room exists. Records leave in the order they were taken.
- R4: When `deq_req` is 1 and `deq_valid` is 1, the head record is removed at the edge. A `deq_req` on an empty output stage changes neither `out_count` nor `free_regs`.
- R5: A squash removes from both stages every record whose sequence number is greater than `squash_seq`, and keeps every record whose sequence number is less than or equal to it.
- R6: A taken write lowers `free_regs` by its `enq_dst`. Each record removed by a squash adds its destination count back to `free_regs`. Without a squash or a release, `free_regs` never rises.
- R7: `rel_cnt` is added to `free_regs`. The sum of the current count, squash refunds and `rel_cnt` is clipped at PHYS_REGS, and only then is any debit applied.
- R8: `reg_blocked` is set when a write is refused because `enq_dst` is greater than `free_regs`, or when a taken write leaves `free_regs` at 0. It is cleared by a squash or a nonzero release that leaves the credited count above 0. While it is set, `enq_ready` is 0.
- R9: At every edge, `occ_sum` grows by the `in_count` held before that edge. `full_cycles` grows by one when that count equals IN_DEPTH.
- R10: When a squash and a write fall in the same cycle, the squash acts first. The new record is kept, and debited, only if `enq_seq` is less than or equal to `squash_seq`.
- R11: If the squash in a cycle removes the output head, `deq_valid` is 0 in that cycle and a `deq_req` pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Fetch offers a record |
| enq_seq | input | SEQ_W | Sequence number of the offered record |
| enq_dst | input | DST_W | Destination register count of the offered record |
| enq_ready | output | 1 | Input stage has space and fetch is not blocked |
| deq_req | input | 1 | Back end takes the head record |
| deq_valid | output | 1 | Output head is present and survives this cycle's squash |
| deq_seq | output | SEQ_W | Sequence number of the output head |
| deq_dst | output | DST_W | Destination count of the output head |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest sequence number that survives |
| rel_cnt | input | FREE_W | Registers returned by the back end this cycle |
| free_regs | output | FREE_W | Free physical register count |
| reg_blocked | output | 1 | Fetch blocked for lack of registers |
| in_count | output | IN_CW | Records in the input stage |
| out_count | output | OUT_CW | Records in the output stage |
| occ_sum | output | ACC_W | Accumulated input-stage occupancy |
| full_cycles | output | ACC_W | Cycles with the input stage full |

## Verification
Three kinds of same-cycle collision are the risky cases.

A squash can land in the same cycle as a write. The bench offers one record with a sequence number just above the squash point and, in another cycle, exactly at it. It expects the first to vanish without touching `free_regs` and the second to be kept and debited.

A squash can also land in the same cycle as a dequeue of a head that the squash kills. The bench drives both together and expects `deq_valid` to read 0 before the edge and both stages to be empty afterwards.

A release and a refusal for registers are also placed in neighbouring cycles. The bench then judges the set and the clearing of the block against `free_regs`.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
   typedef logic [31:0] wide_t;

   function automatic wide_t clip(input wide_t v, input wide_t lim);
      return (v > lim) ? lim : v;
   endfunction
endpackage

// File: rtl/sfq_stage.sv
module sfq_stage #(
   parameter int SEQ_W = 16,
   parameter int DST_W = 3,
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq,
   input  logic             push,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic [DST_W-1:0] push_dst,
   input  logic             pop,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] keep,
   output sfq_pkg::wide_t   refund,
   output logic [SEQ_W-1:0] head_seq,
   output logic [DST_W-1:0] head_dst
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [SEQ_W-1:0] seq_mem [DEPTH];
   logic [DST_W-1:0] dst_mem [DEPTH];
   logic [PTR_W-1:0] head;
   logic [PTR_W-1:0] wr_ptr;

   function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W:0] x);
      if (POW2) return x[PTR_W-1:0];
      return (int'(x) >= DEPTH) ? PTR_W'(int'(x) - DEPTH) : x[PTR_W-1:0];
   endfunction

   // surviving prefix and refund of the squashed tail
   always_comb begin
      keep   = '0;
      refund = '0;
      for (int i = 0; i < DEPTH; i++) begin
         logic [PTR_W-1:0] ix;
         ix = wrap({1'b0, head} + (PTR_W + 1)'(i));
         if (i < int'(count)) begin
            if (sq_valid && (seq_mem[ix] > sq_seq))
               refund = refund + sfq_pkg::wide_t'(dst_mem[ix]);
            else
               keep = keep + CNT_W'(1);
         end
      end
   end

   assign wr_ptr   = wrap({1'b0, head} + (PTR_W + 1)'(keep));
   assign head_seq = seq_mem[head];
   assign head_dst = dst_mem[head];

   always_ff @(posedge clk) begin
      if (push) begin
         seq_mem[wr_ptr] <= push_seq;
         dst_mem[wr_ptr] <= push_dst;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         if (pop) head <= wrap({1'b0, head} + (PTR_W + 1)'(1));
         count <= keep - CNT_W'(pop) + CNT_W'(push);
      end
   end
endmodule

// File: rtl/sfq_delay.sv
module sfq_delay #(
   parameter int SEQ_W   = 16,
   parameter int LATENCY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SEQ_W-1:0] in_seq,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq,
   output logic             aged
);
   generate
      if (LATENCY == 1) begin : g_one
         logic             v1;
         logic [SEQ_W-1:0] s1;
         always_ff @(posedge clk) begin
            if (!rst_n) v1 <= 1'b0;
            else        v1 <= in_valid;
            s1 <= in_seq;
         end
         assign aged = v1 && !(sq_valid && (s1 > sq_seq));
      end else begin : g_chain
         logic [LATENCY-1:0] v;
         logic [SEQ_W-1:0]   s [LATENCY];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v <= '0;
            end else begin
               v[0] <= in_valid;
               for (int k = 1; k < LATENCY; k++)
                  v[k] <= v[k-1] && !(sq_valid && (s[k-1] > sq_seq));
            end
            s[0] <= in_seq;
            for (int k = 1; k < LATENCY; k++) s[k] <= s[k-1];
         end
         assign aged = v[LATENCY-1] && !(sq_valid && (s[LATENCY-1] > sq_seq));
      end
   endgenerate
endmodule

// File: rtl/sfq_stats.sv
module sfq_stats #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] occ,
   output logic [ACC_W-1:0] occ_sum,
   output logic [ACC_W-1:0] full_cycles
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_sum     <= '0;
         full_cycles <= '0;
      end else begin
         occ_sum <= occ_sum + ACC_W'(occ);
         if (int'(occ) == DEPTH) full_cycles <= full_cycles + ACC_W'(1);
      end
   end
endmodule

// File: rtl/squash_fetch_queue.sv
module squash_fetch_queue #(
   parameter int SEQ_W     = 16,
   parameter int DST_W     = 3,
   parameter int IN_DEPTH  = 8,
   parameter int OUT_DEPTH = 4,
   parameter int LATENCY   = 2,
   parameter int PHYS_REGS = 64,
   parameter int ACC_W     = 32,
   parameter int IN_CW     = $clog2(IN_DEPTH + 1),
   parameter int OUT_CW    = $clog2(OUT_DEPTH + 1),
   parameter int FREE_W    = $clog2(PHYS_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [SEQ_W-1:0]  enq_seq,
   input  logic [DST_W-1:0]  enq_dst,
   output logic              enq_ready,
   input  logic              deq_req,
   output logic              deq_valid,
   output logic [SEQ_W-1:0]  deq_seq,
   output logic [DST_W-1:0]  deq_dst,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic [FREE_W-1:0] rel_cnt,
   output logic [FREE_W-1:0] free_regs,
   output logic              reg_blocked,
   output logic [IN_CW-1:0]  in_count,
   output logic [OUT_CW-1:0] out_count,
   output logic [ACC_W-1:0]  occ_sum,
   output logic [ACC_W-1:0]  full_cycles
);
   import sfq_pkg::*;

   generate
      if (IN_DEPTH < 1 || OUT_DEPTH < 1) begin : g_bad_depth
         $error("stage depths must be at least one");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("latency must be at least one cycle");
      end
      if (PHYS_REGS < 1) begin : g_bad_regs
         $error("register pool must be non-empty");
      end
   endgenerate

   logic [IN_CW-1:0]  in_keep, ready_q, rdy_kept, avail;
   logic [OUT_CW-1:0] out_keep;
   wide_t             in_ref, out_ref, credit, sat, debit;
   logic [SEQ_W-1:0]  in_head_seq;
   logic [DST_W-1:0]  in_head_dst;
   logic              aged, pop_out, out_room, xfer;
   logic              enq_fit, enq_drop, enq_ok;
   logic [FREE_W-1:0] free_q;
   logic              blk_q, blk_d;

   sfq_stage #(.SEQ_W(SEQ_W), .DST_W(DST_W), .DEPTH(IN_DEPTH), .CNT_W(IN_CW)) u_in (
      .clk(clk), .rst_n(rst_n), .sq_valid(squash_valid), .sq_seq(squash_seq),
      .push(enq_ok), .push_seq(enq_seq), .push_dst(enq_dst), .pop(xfer),
      .count(in_count), .keep(in_keep), .refund(in_ref),
      .head_seq(in_head_seq), .head_dst(in_head_dst));

   sfq_stage #(.SEQ_W(SEQ_W), .DST_W(DST_W), .DEPTH(OUT_DEPTH), .CNT_W(OUT_CW)) u_out (
      .clk(clk), .rst_n(rst_n), .sq_valid(squash_valid), .sq_seq(squash_seq),
      .push(xfer), .push_seq(in_head_seq), .push_dst(in_head_dst), .pop(pop_out),
      .count(out_count), .keep(out_keep), .refund(out_ref),
      .head_seq(deq_seq), .head_dst(deq_dst));

   sfq_delay #(.SEQ_W(SEQ_W), .LATENCY(LATENCY)) u_dly (
      .clk(clk), .rst_n(rst_n), .in_valid(enq_ok), .in_seq(enq_seq),
      .sq_valid(squash_valid), .sq_seq(squash_seq), .aged(aged));

   sfq_stats #(.DEPTH(IN_DEPTH), .CNT_W(IN_CW), .ACC_W(ACC_W)) u_stats (
      .clk(clk), .rst_n(rst_n), .occ(in_count),
      .occ_sum(occ_sum), .full_cycles(full_cycles));

   // output side: head survives only if the squash keeps something
   assign deq_valid = (out_keep != '0);
   assign pop_out   = deq_req && deq_valid;

   // eligibility: records already aged plus the one aging now
   assign rdy_kept = (ready_q < in_keep) ? ready_q : in_keep;
   assign avail    = rdy_kept + IN_CW'(aged);
   assign out_room = (int'(out_keep) - int'(pop_out)) < OUT_DEPTH;
   assign xfer     = (avail != '0) && out_room;

   // input side: squash resolved before the write
   assign enq_ready = !blk_q && (int'(in_count) < IN_DEPTH);
   assign enq_fit   = int'(enq_dst) <= int'(free_q);
   assign enq_drop  = squash_valid && (enq_seq > squash_seq);
   assign enq_ok    = enq_valid && enq_ready && enq_fit && !enq_drop;

   // register pool: credit, clip, then debit
   assign credit = wide_t'(free_q) + in_ref + out_ref + wide_t'(rel_cnt);
   assign sat    = clip(credit, wide_t'(PHYS_REGS));
   assign debit  = enq_ok ? wide_t'(enq_dst) : '0;

   always_comb begin
      blk_d = blk_q;
      if ((squash_valid || (rel_cnt != '0)) && (sat != '0)) blk_d = 1'b0;
      if (enq_valid && enq_ready && !enq_fit) blk_d = 1'b1;
      if (enq_ok && (sat == debit)) blk_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q  <= FREE_W'(PHYS_REGS);
         blk_q   <= 1'b0;
         ready_q <= '0;
      end else begin
         free_q  <= FREE_W'(sat - debit);
         blk_q   <= blk_d;
         ready_q <= avail - IN_CW'(xfer);
      end
   end

   assign free_regs   = free_q;
   assign reg_blocked = blk_q;
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
   parameter int SEQ_W     = 16,
   parameter int IN_DEPTH  = 8,
   parameter int PHYS_REGS = 64,
   parameter int ACC_W     = 32,
   parameter int IN_CW     = $clog2(IN_DEPTH + 1),
   parameter int FREE_W    = $clog2(PHYS_REGS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enq_ready,
   input logic              reg_blocked,
   input logic              deq_valid,
   input logic [SEQ_W-1:0]  deq_seq,
   input logic              squash_valid,
   input logic [SEQ_W-1:0]  squash_seq,
   input logic [FREE_W-1:0] rel_cnt,
   input logic [FREE_W-1:0] free_regs,
   input logic [IN_CW-1:0]  in_count,
   input logic [ACC_W-1:0]  full_cycles
);
   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(in_count) <= IN_DEPTH);

   // R7
   free_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_regs) <= PHYS_REGS);

   // R8
   block_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_blocked |-> !enq_ready);

   // R6
   credit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!squash_valid && (rel_cnt == '0)) |=> (free_regs <= $past(free_regs)));

   // R5
   squash_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> (!deq_valid || (deq_seq <= $past(squash_seq))));

   // R9
   full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(in_count) == IN_DEPTH) |=> (full_cycles == ACC_W'($past(full_cycles) + 1'b1)));
endmodule

bind squash_fetch_queue sfq_checker #(
   .SEQ_W(SEQ_W), .IN_DEPTH(IN_DEPTH), .PHYS_REGS(PHYS_REGS), .ACC_W(ACC_W),
   .IN_CW(IN_CW), .FREE_W(FREE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .reg_blocked(reg_blocked),
   .deq_valid(deq_valid), .deq_seq(deq_seq), .squash_valid(squash_valid),
   .squash_seq(squash_seq), .rel_cnt(rel_cnt), .free_regs(free_regs),
   .in_count(in_count), .full_cycles(full_cycles)
);

// File: tb/squash_fetch_queue_test.sv
`timescale 1ns/1ps
module squash_fetch_queue_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enq_valid = 1'b0, deq_req = 1'b0, squash_valid = 1'b0;
   logic [15:0] enq_seq = '0, squash_seq = '0;
   logic [2:0]  enq_dst = '0;
   logic [3:0]  rel_cnt = '0;
   logic        enq_ready, deq_valid, reg_blocked;
   logic [15:0] deq_seq;
   logic [2:0]  deq_dst, in_count;
   logic [1:0]  out_count;
   logic [3:0]  free_regs;
   logic [15:0] occ_sum, full_cycles;
   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   squash_fetch_queue #(.SEQ_W(16), .DST_W(3), .IN_DEPTH(4), .OUT_DEPTH(2),
      .LATENCY(2), .PHYS_REGS(8), .ACC_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_seq(enq_seq),
      .enq_dst(enq_dst), .enq_ready(enq_ready), .deq_req(deq_req),
      .deq_valid(deq_valid), .deq_seq(deq_seq), .deq_dst(deq_dst),
      .squash_valid(squash_valid), .squash_seq(squash_seq), .rel_cnt(rel_cnt),
      .free_regs(free_regs), .reg_blocked(reg_blocked), .in_count(in_count),
      .out_count(out_count), .occ_sum(occ_sum), .full_cycles(full_cycles));

   typedef struct packed {
      logic        ev; logic [15:0] es; logic [2:0] ed; logic dq;
      logic        sv; logic [15:0] ss; logic [3:0] rl;
      logic [2:0]  xi; logic [1:0] xo; logic [3:0] xf;
   } vec_t;

   // stimulus, then expected in_count, out_count, free_regs after the edge
   localparam vec_t VECS [15] = '{
      '{1'b1, 16'd1, 3'd2, 1'b0, 1'b0, 16'd0, 4'd0, 3'd1, 2'd0, 4'd6},
      '{1'b1, 16'd2, 3'd1, 1'b0, 1'b0, 16'd0, 4'd0, 3'd2, 2'd0, 4'd5},
      '{1'b1, 16'd3, 3'd3, 1'b0, 1'b0, 16'd0, 4'd0, 3'd2, 2'd1, 4'd2},
      '{1'b0, 16'd0, 3'd0, 1'b0, 1'b0, 16'd0, 4'd0, 3'd1, 2'd2, 4'd2},
      '{1'b0, 16'd0, 3'd0, 1'b0, 1'b0, 16'd0, 4'd0, 3'd1, 2'd2, 4'd2},
      '{1'b0, 16'd0, 3'd0, 1'b1, 1'b0, 16'd0, 4'd0, 3'd0, 2'd2, 4'd2},
      '{1'b1, 16'd4, 3'd2, 1'b0, 1'b0, 16'd0, 4'd0, 3'd1, 2'd2, 4'd0},
      '{1'b1, 16'd5, 3'd0, 1'b0, 1'b0, 16'd0, 4'd0, 3'd1, 2'd2, 4'd0},
      '{1'b0, 16'd0, 3'd0, 1'b0, 1'b0, 16'd0, 4'd3, 3'd1, 2'd2, 4'd3},
      '{1'b0, 16'd0, 3'd0, 1'b0, 1'b1, 16'd2, 4'd0, 3'd0, 2'd1, 4'd8},
      '{1'b0, 16'd0, 3'd0, 1'b0, 1'b0, 16'd0, 4'd5, 3'd0, 2'd1, 4'd8},
      '{1'b0, 16'd0, 3'd0, 1'b1, 1'b0, 16'd0, 4'd0, 3'd0, 2'd0, 4'd8},
      '{1'b0, 16'd0, 3'd0, 1'b1, 1'b0, 16'd0, 4'd0, 3'd0, 2'd0, 4'd8},
      '{1'b1, 16'd6, 3'd1, 1'b0, 1'b1, 16'd5, 4'd0, 3'd0, 2'd0, 4'd8},
      '{1'b1, 16'd6, 3'd1, 1'b0, 1'b1, 16'd6, 4'd0, 3'd1, 2'd0, 4'd7}
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic cyc(input logic ev, input int es, input int ed, input logic dq,
                      input logic sv, input int ss, input int rl);
      @(negedge clk);
      enq_valid = ev; enq_seq = 16'(es); enq_dst = 3'(ed); deq_req = dq;
      squash_valid = sv; squash_seq = 16'(ss); rel_cnt = 4'(rl);
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      enq_valid = 0; deq_req = 0; squash_valid = 0; rel_cnt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      do_reset();
      #1;
      // R1 reset state
      check("R1 in_count", int'(in_count), 0);
      check("R1 out_count", int'(out_count), 0);
      check("R1 free_regs", int'(free_regs), 8);
      check("R1 reg_blocked", int'(reg_blocked), 0);
      check("R1 deq_valid", int'(deq_valid), 0);
      check("R1 enq_ready", int'(enq_ready), 1);
      check("R1 occ_sum", int'(occ_sum), 0);
      check("R1 full_cycles", int'(full_cycles), 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R10
      for (int v = 0; v < 15; v++) begin
         cyc(VECS[v].ev, int'(VECS[v].es), int'(VECS[v].ed), VECS[v].dq,
             VECS[v].sv, int'(VECS[v].ss), int'(VECS[v].rl));
         check($sformatf("R3 R5 R10 in_count step %0d", v), int'(in_count), int'(VECS[v].xi));
         check($sformatf("R3 R4 R5 out_count step %0d", v), int'(out_count), int'(VECS[v].xo));
         check($sformatf("R6 R7 R8 free_regs step %0d", v), int'(free_regs), int'(VECS[v].xf));
      end

      // fill, latency, full and statistics
      do_reset();
      for (int k = 1; k <= 6; k++) begin
         cyc(1'b1, k, 1, 1'b0, 1'b0, 0, 0);
         if (k == 3) begin
            check("R3 deq_valid after latency", int'(deq_valid), 1);
            check("R3 deq_seq oldest first", int'(deq_seq), 1);
         end
      end
      check("R2 in_count at depth", int'(in_count), 4);
      check("R2 enq_ready when full", int'(enq_ready), 0);
      cyc(1'b1, 7, 1, 1'b0, 1'b0, 0, 0);
      check("R2 write refused when full", int'(in_count), 4);
      check("R2 no debit when refused", int'(free_regs), 2);
      check("R9 occ_sum", int'(occ_sum), 14);
      check("R9 full_cycles", int'(full_cycles), 1);
      cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 0);
      check("R9 occ_sum idle full", int'(occ_sum), 18);
      check("R9 full_cycles idle full", int'(full_cycles), 2);

      // R11 squash kills the head in the dequeue cycle
      @(negedge clk);
      enq_valid = 0; squash_valid = 1; squash_seq = 16'd0; deq_req = 1;
      #1;
      check("R11 deq_valid hidden by squash", int'(deq_valid), 0);
      @(posedge clk);
      #1;
      check("R5 input emptied", int'(in_count), 0);
      check("R5 output emptied", int'(out_count), 0);
      check("R6 refund of squashed records", int'(free_regs), 8);

      // R8 refusal for registers, then release
      cyc(1'b1, 10, 7, 1'b0, 1'b0, 0, 0);
      check("R6 debit", int'(free_regs), 1);
      cyc(1'b1, 11, 3, 1'b0, 1'b0, 0, 0);
      check("R8 blocked on shortage", int'(reg_blocked), 1);
      check("R8 enq_ready while blocked", int'(enq_ready), 0);
      check("R8 free after refusal", int'(free_regs), 1);
      check("R8 refused write not stored", int'(in_count), 1);
      cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 1);
      check("R8 released free", int'(free_regs), 2);
      check("R8 block cleared by release", int'(reg_blocked), 0);

      cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 0);
      finish_run();
   end
endmodule